// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block turns one fast timing input into the clocking and control signals that a processor core and its peripherals need. A source-select input picks either an internal oscillator clock or an external frequency input. The chosen source drives a divide-by-three stage, which produces the processor clock with a one-third high duty cycle. A divide-by-two stage on the processor-clock rate then produces a peripheral clock at one sixth of the source frequency with a 50% duty cycle.

The same divide-by-three stage sets the timing for two control paths. The first path samples an active-low reset request through one flip-flop and drives it out as an active-high processor reset. That reset is then held for four more processor periods after the request is released. The second path handles two ready requests. Each is qualified by its own active-low enable, the two are combined, and the result passes through one or two synchronizer stages, chosen by a select input. All internal state advances only on processor-clock rising edges, written as a clock enable on the source clock. A power-on reset clears the divider phases so that they start in a known state.

Top module: `proc_clkgen`

## Requirements
- R1: With `src_sel_i` = 0 the dividers run from `osc_clk_i`, and with `src_sel_i` = 1 they run from `ext_clk_i`. The period of `cpu_clk_o` is three periods of the selected source.
- R2: `cpu_clk_o` is high for exactly one source period and low for two source periods in each of its cycles.
- R3: `per_clk_o` has a period of six source periods. It is high for three and low for three, and it changes only on a rising edge of `cpu_clk_o`.
- R4: While `por_ni` is low, `cpu_clk_o` and `per_clk_o` are 0, `cpu_rst_o` is 1 and `cpu_rdy_o` is 0, whatever the other inputs are.
- R5: `rst_req_ni` is sampled by one flip-flop on each `cpu_clk_o` rising edge. A low request drives `cpu_rst_o` high within one processor period, and `cpu_rst_o` stays high for as long as the request stays low.
- R6: After the release of `rst_req_ni` is sampled, `cpu_rst_o` stays high for four more processor periods. It falls 13 to 15 source periods after the release, depending on the divider phase.
- R7: The combined ready request is (`rdy_a_i` AND NOT `rdy_a_en_ni`) OR (`rdy_b_i` AND NOT `rdy_b_en_ni`). A request whose enable is high has no effect on `cpu_rdy_o`.
- R8: With `rdy_two_i` = 0, `cpu_rdy_o` takes the combined request value at the first `cpu_clk_o` rising edge after the request changes. With `rdy_two_i` = 1, it does so at the second rising edge.
- R9: `cpu_rst_o` and `cpu_rdy_o` change only on a rising edge of `cpu_clk_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk_i | input | 1 | Internal oscillator stand-in clock |
| ext_clk_i | input | 1 | External frequency input clock |
| src_sel_i | input | 1 | Timing source select: 0 oscillator, 1 external |
| por_ni | input | 1 | Asynchronous active-low power-on reset |
| rst_req_ni | input | 1 | Active-low processor reset request |
| rdy_a_i | input | 1 | Ready request A |
| rdy_a_en_ni | input | 1 | Active-low enable qualifying request A |
| rdy_b_i | input | 1 | Ready request B |
| rdy_b_en_ni | input | 1 | Active-low enable qualifying request B |
| rdy_two_i | input | 1 | Ready synchronizer depth: 0 one stage, 1 two stages |
| cpu_clk_o | output | 1 | Processor clock, source/3, one-third high |
| per_clk_o | output | 1 | Peripheral clock, source/6, 50% duty |
| cpu_rst_o | output | 1 | Active-high processor reset |
| cpu_rdy_o | output | 1 | Synchronized ready |

## Verification
If the divide-by-three counter enters a bad phase or skips a count, the fault appears within one processor period: the `cpu_clk_o` high pulse becomes wider or shifts, and `per_clk_o` loses its 3/3 split within six source periods. If the reset-hold counter loads or counts down incorrectly, `cpu_rst_o` falls outside the 13-to-15 source-period window after a request release. If a ready synchronizer stage is wrong, the output moves one processor edge early or late compared with the selected depth. If the qualification is wrong, it shows within two processor edges as a wrong level on `cpu_rdy_o`.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic {
    RDY_DEPTH_ONE = 1'b0,
    RDY_DEPTH_TWO = 1'b1
  } rdy_depth_e;

  localparam int unsigned CPU_DIV_DEF   = 3;
  localparam int unsigned PER_RATIO_DEF = 2;
  localparam int unsigned RST_HOLD_DEF  = 4;
  localparam int unsigned RDY_STAGE_DEF = 2;
endpackage

// File: rtl/pcg_cpu_div.sv
module pcg_cpu_div #(
  parameter int unsigned DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cpu_clk_o,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clk_q, clk_d;

  always_comb begin
    tick_o = (cnt_q >= LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    clk_d  = tick_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign cpu_clk_o = clk_q;

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_high_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_q |=> !clk_q);

  if (DIV >= 3) begin : g_low_span
    p_low_span_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(clk_q) |=> !clk_q);
  end
endmodule

// File: rtl/pcg_per_div.sv
module pcg_per_div #(
  parameter int unsigned RATIO = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic per_clk_o
);
  localparam int unsigned HALF = (RATIO >= 2) ? RATIO / 2 : 1;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clk_q, clk_d;

  always_comb begin
    cnt_d = cnt_q;
    clk_d = clk_q;
    if (tick_i) begin
      if (cnt_q >= LAST) begin
        cnt_d = '0;
        clk_d = ~clk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign per_clk_o = clk_q;

  p_per_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(clk_q));
endmodule

// File: rtl/pcg_rst_sync.sv
module pcg_rst_sync #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rst_req_ni,
  output logic cpu_rst_o
);
  localparam int unsigned HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic          req_q, req_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    req_d  = req_q;
    hold_d = hold_q;
    if (tick_i) begin
      req_d = ~rst_req_ni;
      if (req_q) begin
        hold_d = HOLD_V;
      end else if (hold_q != '0) begin
        hold_d = hold_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b1;
      hold_q <= HOLD_V;
    end else begin
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  assign cpu_rst_o = req_q | (hold_q != '0);

  p_hold_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && req_q) |=> (hold_q == HOLD_V));
  p_hold_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !req_q && hold_q != '0) |=> (hold_q == $past(hold_q) - 1'b1));
  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(hold_q) && $stable(req_q)));
endmodule

// File: rtl/pcg_rdy_sync.sv
module pcg_rdy_sync
  import pcg_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rdy_a_i,
  input  logic       rdy_a_en_ni,
  input  logic       rdy_b_i,
  input  logic       rdy_b_en_ni,
  input  rdy_depth_e depth_i,
  output logic       rdy_o
);
  logic              req;
  logic [STAGES-1:0] sh_q, sh_d;

  assign req = (rdy_a_i & ~rdy_a_en_ni) | (rdy_b_i & ~rdy_b_en_ni);

  always_comb begin
    sh_d = sh_q;
    if (tick_i) begin
      sh_d[0] = req;
      for (int i = 1; i < int'(STAGES); i++) begin
        sh_d[i] = sh_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  if (STAGES >= 2) begin : g_sel
    assign rdy_o = (depth_i == RDY_DEPTH_TWO) ? sh_q[STAGES-1] : sh_q[0];
  end else begin : g_one
    assign rdy_o = sh_q[0];
  end

  p_first_stage_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (sh_q[0] == $past(req)));
endmodule

// File: rtl/proc_clkgen.sv
module proc_clkgen
  import pcg_pkg::*;
#(
  parameter int unsigned CPU_DIV    = CPU_DIV_DEF,
  parameter int unsigned PER_RATIO  = PER_RATIO_DEF,
  parameter int unsigned RST_HOLD   = RST_HOLD_DEF,
  parameter int unsigned RDY_STAGES = RDY_STAGE_DEF
) (
  input  logic osc_clk_i,
  input  logic ext_clk_i,
  input  logic src_sel_i,
  input  logic por_ni,
  input  logic rst_req_ni,
  input  logic rdy_a_i,
  input  logic rdy_a_en_ni,
  input  logic rdy_b_i,
  input  logic rdy_b_en_ni,
  input  logic rdy_two_i,
  output logic cpu_clk_o,
  output logic per_clk_o,
  output logic cpu_rst_o,
  output logic cpu_rdy_o
);
  logic       src_clk;
  logic [1:0] por_q;
  logic       rst_n;
  logic       tick;
  rdy_depth_e depth;

  assign src_clk = src_sel_i ? ext_clk_i : osc_clk_i;
  assign depth   = rdy_depth_e'(rdy_two_i);

  always_ff @(posedge src_clk or negedge por_ni) begin
    if (!por_ni) begin
      por_q <= '0;
    end else begin
      por_q <= {por_q[0], 1'b1};
    end
  end
  assign rst_n = por_q[1];

  pcg_cpu_div #(.DIV(CPU_DIV)) u_cpu_div (
    .clk_i(src_clk), .rst_ni(rst_n), .cpu_clk_o(cpu_clk_o), .tick_o(tick)
  );

  pcg_per_div #(.RATIO(PER_RATIO)) u_per_div (
    .clk_i(src_clk), .rst_ni(rst_n), .tick_i(tick), .per_clk_o(per_clk_o)
  );

  pcg_rst_sync #(.HOLD(RST_HOLD)) u_rst_sync (
    .clk_i(src_clk), .rst_ni(rst_n), .tick_i(tick),
    .rst_req_ni(rst_req_ni), .cpu_rst_o(cpu_rst_o)
  );

  pcg_rdy_sync #(.STAGES(RDY_STAGES)) u_rdy_sync (
    .clk_i(src_clk), .rst_ni(rst_n), .tick_i(tick),
    .rdy_a_i(rdy_a_i), .rdy_a_en_ni(rdy_a_en_ni),
    .rdy_b_i(rdy_b_i), .rdy_b_en_ni(rdy_b_en_ni),
    .depth_i(depth), .rdy_o(cpu_rdy_o)
  );

  p_per_on_cpu_edge_r3: assert property (@(posedge src_clk) disable iff (!rst_n)
    !$stable(per_clk_o) |-> $rose(cpu_clk_o));
  p_rst_on_cpu_edge_r9: assert property (@(posedge src_clk) disable iff (!rst_n)
    !$stable(cpu_rst_o) |-> $rose(cpu_clk_o));
  p_rdy_on_cpu_edge_r9: assert property (@(posedge src_clk) disable iff (!rst_n)
    !$stable(cpu_rdy_o) |-> $rose(cpu_clk_o));
endmodule

// File: tb/proc_clkgen_tb_top.sv
module proc_clkgen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_PERIOD = 14;

  // vector: {rdy_two, rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n, expected}
  localparam logic [5:0] VEC [0:7] = '{
    6'b0_1_0_0_1_1,
    6'b0_1_1_0_1_0,
    6'b0_0_0_1_0_1,
    6'b0_0_1_1_1_0,
    6'b1_1_1_1_0_1,
    6'b1_0_0_0_0_0,
    6'b1_1_0_1_0_1,
    6'b0_1_1_1_1_0
  };

  logic osc_clk = 1'b0;
  logic ext_clk = 1'b0;
  logic src_sel, por_n, rst_req_n;
  logic rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n, rdy_two;
  logic cpu_clk, per_clk, cpu_rst, cpu_rdy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) osc_clk = ~osc_clk;
  always #(EXT_PERIOD / 2) ext_clk = ~ext_clk;

  proc_clkgen dut_i (
    .osc_clk_i(osc_clk), .ext_clk_i(ext_clk), .src_sel_i(src_sel),
    .por_ni(por_n), .rst_req_ni(rst_req_n),
    .rdy_a_i(rdy_a), .rdy_a_en_ni(rdy_a_en_n),
    .rdy_b_i(rdy_b), .rdy_b_en_ni(rdy_b_en_n), .rdy_two_i(rdy_two),
    .cpu_clk_o(cpu_clk), .per_clk_o(per_clk),
    .cpu_rst_o(cpu_rst), .cpu_rdy_o(cpu_rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  task automatic align_cpu();
    @(posedge cpu_clk);
    @(negedge osc_clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int cpu_hi, per_hi, cpu_run, per_hrun, per_lrun, cpu_max, per_hmax, per_lmax, bad_edge;
    logic pc, pp;
    longint t0, t1;

    src_sel = 1'b0; por_n = 1'b1; rst_req_n = 1'b0;
    rdy_a = 1'b1; rdy_a_en_n = 1'b0; rdy_b = 1'b0; rdy_b_en_n = 1'b1; rdy_two = 1'b0;
    #2 por_n = 1'b0;
    wait_neg(6);
    // R4: power-on reset state with a qualified ready request present
    chk("R4 cpu_clk", 32'(cpu_clk), 0);
    chk("R4 per_clk", 32'(per_clk), 0);
    chk("R4 cpu_rst", 32'(cpu_rst), 1);
    chk("R4 cpu_rdy", 32'(cpu_rdy), 0);
    rdy_a = 1'b0;
    por_n = 1'b1;
    wait_neg(20);
    chk("R5 reset held while request low", 32'(cpu_rst), 1);

    // R2, R3: waveform shape over 24 source periods
    cpu_hi = 0; per_hi = 0; cpu_run = 0; per_hrun = 0; per_lrun = 0;
    cpu_max = 0; per_hmax = 0; per_lmax = 0; bad_edge = 0;
    @(negedge osc_clk);
    pc = cpu_clk; pp = per_clk;
    for (int i = 0; i < 24; i++) begin
      @(negedge osc_clk);
      if (cpu_clk) begin cpu_hi++; cpu_run++; end else cpu_run = 0;
      if (cpu_run > cpu_max) cpu_max = cpu_run;
      if (per_clk) begin per_hi++; per_hrun++; per_lrun = 0; end
      else begin per_lrun++; per_hrun = 0; end
      if (per_hrun > per_hmax) per_hmax = per_hrun;
      if (per_lrun > per_lmax) per_lmax = per_lrun;
      if ((per_clk != pp) && !(cpu_clk && !pc)) bad_edge++;
      pc = cpu_clk; pp = per_clk;
    end
    chk("R2 cpu_clk high count in 24", 32'(cpu_hi), 8);
    chk("R2 cpu_clk longest high run", 32'(cpu_max), 1);
    chk("R3 per_clk high count in 24", 32'(per_hi), 12);
    chk("R3 per_clk longest high run", 32'(per_hmax), 3);
    chk("R3 per_clk longest low run", 32'(per_lmax), 3);
    chk("R3 per_clk edges off cpu rise", 32'(bad_edge), 0);

    // R6: release and hold window
    rst_req_n = 1'b1;
    n = 0;
    do begin
      @(negedge osc_clk);
      n++;
    end while (cpu_rst && n < 40);
    chk("R6 release to reset fall within 13..15", 32'(n >= 13 && n <= 15), 1);
    chk("R9 reset fall on cpu rise", 32'(cpu_clk), 1);

    // R5: reassert
    wait_neg(7);
    rst_req_n = 1'b0;
    n = 0;
    do begin
      @(negedge osc_clk);
      n++;
    end while (!cpu_rst && n < 40);
    chk("R5 reassert within one cpu period", 32'(n >= 1 && n <= 3), 1);
    chk("R9 reset rise on cpu rise", 32'(cpu_clk), 1);
    rst_req_n = 1'b1;
    wait_neg(30);
    chk("R6 reset low after hold", 32'(cpu_rst), 0);

    // R7: qualification table
    for (int v = 0; v < 8; v++) begin
      {rdy_two, rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n} = VEC[v][5:1];
      wait_neg(9);
      chk($sformatf("R7 vector %0d", v), 32'(cpu_rdy), 32'(VEC[v][0]));
    end

    // R8: depth one latency
    rdy_a = 1'b0; rdy_b = 1'b0; rdy_a_en_n = 1'b0; rdy_b_en_n = 1'b0; rdy_two = 1'b0;
    wait_neg(9);
    align_cpu();
    rdy_a = 1'b1;
    align_cpu();
    chk("R8 depth one after first edge", 32'(cpu_rdy), 1);
    // R8: depth two latency
    rdy_two = 1'b1;
    rdy_a = 1'b0;
    wait_neg(9);
    align_cpu();
    rdy_a = 1'b1;
    align_cpu();
    chk("R8 depth two after first edge", 32'(cpu_rdy), 0);
    align_cpu();
    chk("R8 depth two after second edge", 32'(cpu_rdy), 1);
    // R7: disabled request does not lower or raise ready
    rdy_a_en_n = 1'b1; rdy_b = 1'b0;
    wait_neg(9);
    chk("R7 disabled request ignored", 32'(cpu_rdy), 0);

    // R1: external source
    src_sel = 1'b1;
    repeat (20) @(posedge ext_clk);
    @(posedge cpu_clk); t0 = $time;
    @(posedge cpu_clk); t1 = $time;
    chk("R1 cpu period on external source", 32'(t1 - t0), 3 * EXT_PERIOD);
    @(posedge per_clk); t0 = $time;
    @(posedge per_clk); t1 = $time;
    chk("R1 per period on external source", 32'(t1 - t0), 6 * EXT_PERIOD);
    src_sel = 1'b0;
    repeat (20) @(posedge osc_clk);
    @(posedge cpu_clk); t0 = $time;
    @(posedge cpu_clk); t1 = $time;
    chk("R1 cpu period on oscillator", 32'(t1 - t0), 3 * CLK_PERIOD);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule